// File: doc/BRIEF.md
# Three-Bank Prioritized Interrupt Resolver

This block gathers level-sensitive interrupt sources into three 8-bit banks: a low bank, a high bank and a DMA bank. Each bank keeps a raw status byte and an enable mask. Its request byte is the status ANDed with the mask. Each cycle, a combinational network picks one winner from all pending, enabled requests and turns it into a 5-bit vector number. That number is registered, together with a valid flag, and drives the interrupt output.

Software reaches the block through a byte-wide port. Reads are combinational and writes are single-cycle strobes. Software enables and disables sources by read-modify-write of the mask byte. Low-bank events are latched and stay latched until software writes ones to clear them. High-bank and DMA-bank status simply follow their source lines.

Each bank has its own fixed winning order, and these orders are not lowest-index-first. Across banks, the high bank always beats the DMA bank, and the DMA bank always beats the low bank.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Bank bases are 0x10 (low), 0x20 (high) and 0x30 (DMA). Inside a bank, offset 0x0 reads status, offset 0x4 reads request, and offset 0x8 reads and writes the mask. Any other address reads 0x00.
- R2: A bank's request byte equals its status byte ANDed with its mask byte. A masked source never produces a vector.
- R3: During reset and after it, all three masks read 0x00, and irq_valid and irq_vector are 0.
- R4: A low-bank status bit is set on any rising clock edge where its source is high. It stays set after the source falls, until a write to 0x14 with a one in that bit clears it.
- R5: Writes to 0x24 and 0x34 leave the high and DMA status bytes unchanged.
- R6: The high bank is considered first, then the DMA bank, then the low bank. A lower bank wins only when every bank above it has no request.
- R7: In the high bank, bits win in the order 2, 3, 5, 7, 6, 0, 1, 4 (first listed wins), and the vector is 8 plus the bit index.
- R8: In the DMA bank, only bits 0 to 5 have sources (src_dma). Bits win in the order 0, 1, 2, 3, 5, 4, the vector is 16 plus the bit index, and vectors 22 and 23 never appear.
- R9: In the low bank, bits win in the order 7, 5, 3, 6, 2, 0, 1, 4, and the vector is the bit index.
- R10: irq_valid is 1 exactly when some request is pending, so vector 0 with irq_valid = 1 differs from the idle state. irq_vector is 0 whenever irq_valid is 0.
- R11: irq_valid and irq_vector are registered. They reflect status and mask one rising edge after the change becomes visible: a change on src_high appears after the next edge, and a latched low-bank event appears one edge after it is latched.
- R12: If a low-bank clear write and a high source level hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_low | input | 8 | Low-bank source levels (latched) |
| src_high | input | 8 | High-bank source levels |
| src_dma | input | 6 | DMA-bank source levels |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| irq_valid | output | 1 | A request is pending |
| irq_vector | output | 5 | Winning vector number |

## Verification
The embedded properties check several rules on every cycle:
- each bank picker only names a bit that is actually requesting;
- latched low-bank bits never drop without a clear write;
- the vector falls in the range of the bank that had requests one edge earlier;
- the masks are zero after reset.

Only the bench scenarios can show the full winning order inside each bank and the address map. They also cover the ignored clear writes on the high and DMA banks, the clear/set collision, and the exact one-edge output latency. These behaviours depend on specific stimulus sequences and known expected vectors.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int BANK_W = 8;
    localparam int IDX_W  = $clog2(BANK_W);
    localparam int VEC_W  = 5;
    localparam int DMA_SRC = 6;

    localparam logic [VEC_W-1:0] LOW_BASE  = 5'd0;
    localparam logic [VEC_W-1:0] HIGH_BASE = 5'd8;
    localparam logic [VEC_W-1:0] DMA_BASE  = 5'd16;

    // slot k at [k*3 +: 3], slot 0 wins first
    localparam logic [BANK_W*IDX_W-1:0] HIGH_ORDER =
        {3'd4, 3'd1, 3'd0, 3'd6, 3'd7, 3'd5, 3'd3, 3'd2};
    localparam logic [BANK_W*IDX_W-1:0] DMA_ORDER =
        {3'd4, 3'd6, 3'd7, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam logic [BANK_W*IDX_W-1:0] LOW_ORDER =
        {3'd4, 3'd1, 3'd0, 3'd2, 3'd6, 3'd3, 3'd5, 3'd7};

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_LOW  = 2'd1,
        BK_HIGH = 2'd2,
        BK_DMA  = 2'd3
    } bank_sel_e;

    typedef enum logic [1:0] {
        OFF_STAT = 2'd0,
        OFF_REQ  = 2'd1,
        OFF_MASK = 2'd2,
        OFF_NONE = 2'd3
    } reg_off_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int W      = 8,
    parameter int NSRC   = 8,
    parameter bit STICKY = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    stat,
    output logic [W-1:0]    mask,
    output logic [W-1:0]    req
);
    logic [W-1:0] src_w;
    logic [W-1:0] clr_bits;

    always_comb begin
        src_w = '0;
        src_w[NSRC-1:0] = src;
    end

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else if (mask_we) mask <= wdata;
    end

    generate
        if (STICKY) begin : g_latch
            logic [W-1:0] stat_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stat_q <= '0;
                else stat_q <= (stat_q & ~clr_bits) | src_w;
            end
            assign stat = stat_q;

            // R4
            sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_bits == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
            // R12
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (src_w != '0) |=> ((stat_q & $past(src_w)) == $past(src_w)));
        end else begin : g_level
            assign stat = src_w;
        end
    endgenerate

    assign req = stat & mask;

    // R3
    mask_reset_chk: assert property (@(posedge clk) !rst_n |=> (mask == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int W  = 8,
    parameter int IW = 3,
    parameter logic [W*IW-1:0] ORDER = '0
) (
    input  logic [W-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (req[ORDER[k*IW +: IW]]) begin
                hit = 1'b1;
                idx = ORDER[k*IW +: IW];
            end
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BANK_W-1:0]   src_low,
    input  logic [BANK_W-1:0]   src_high,
    input  logic [DMA_SRC-1:0]  src_dma,
    input  logic [5:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [BANK_W-1:0]   reg_wdata,
    output logic [BANK_W-1:0]   reg_rdata,
    output logic                irq_valid,
    output logic [VEC_W-1:0]    irq_vector
);
    bank_sel_e bsel;
    reg_off_e  roff;

    logic [BANK_W-1:0] l_stat, l_mask, l_req;
    logic [BANK_W-1:0] h_stat, h_mask, h_req;
    logic [BANK_W-1:0] d_stat, d_mask, d_req;
    logic              l_hit, h_hit, d_hit;
    logic [IDX_W-1:0]  l_idx, h_idx, d_idx;
    logic              valid_d;
    logic [VEC_W-1:0]  vec_d;

    assign bsel = bank_sel_e'(reg_addr[5:4]);

    always_comb begin
        roff = OFF_NONE;
        if (reg_addr[1:0] == 2'b00) begin
            unique case (reg_addr[3:2])
                2'd0:    roff = OFF_STAT;
                2'd1:    roff = OFF_REQ;
                2'd2:    roff = OFF_MASK;
                default: roff = OFF_NONE;
            endcase
        end
    end

    irq_bank #(.W(BANK_W), .NSRC(BANK_W), .STICKY(1'b1)) u_low (
        .clk(clk), .rst_n(rst_n), .src(src_low),
        .mask_we(reg_wr && bsel == BK_LOW && roff == OFF_MASK),
        .clr_we (reg_wr && bsel == BK_LOW && roff == OFF_REQ),
        .wdata(reg_wdata), .stat(l_stat), .mask(l_mask), .req(l_req));

    irq_bank #(.W(BANK_W), .NSRC(BANK_W), .STICKY(1'b0)) u_high (
        .clk(clk), .rst_n(rst_n), .src(src_high),
        .mask_we(reg_wr && bsel == BK_HIGH && roff == OFF_MASK),
        .clr_we (reg_wr && bsel == BK_HIGH && roff == OFF_REQ),
        .wdata(reg_wdata), .stat(h_stat), .mask(h_mask), .req(h_req));

    irq_bank #(.W(BANK_W), .NSRC(DMA_SRC), .STICKY(1'b0)) u_dma (
        .clk(clk), .rst_n(rst_n), .src(src_dma),
        .mask_we(reg_wr && bsel == BK_DMA && roff == OFF_MASK),
        .clr_we (reg_wr && bsel == BK_DMA && roff == OFF_REQ),
        .wdata(reg_wdata), .stat(d_stat), .mask(d_mask), .req(d_req));

    irq_prio_pick #(.W(BANK_W), .IW(IDX_W), .ORDER(LOW_ORDER))  u_pick_low  (.req(l_req), .hit(l_hit), .idx(l_idx));
    irq_prio_pick #(.W(BANK_W), .IW(IDX_W), .ORDER(HIGH_ORDER)) u_pick_high (.req(h_req), .hit(h_hit), .idx(h_idx));
    irq_prio_pick #(.W(BANK_W), .IW(IDX_W), .ORDER(DMA_ORDER))  u_pick_dma  (.req(d_req), .hit(d_hit), .idx(d_idx));

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (bsel)
            BK_LOW:  reg_rdata = (roff == OFF_STAT) ? l_stat : (roff == OFF_REQ) ? l_req :
                                 (roff == OFF_MASK) ? l_mask : '0;
            BK_HIGH: reg_rdata = (roff == OFF_STAT) ? h_stat : (roff == OFF_REQ) ? h_req :
                                 (roff == OFF_MASK) ? h_mask : '0;
            BK_DMA:  reg_rdata = (roff == OFF_STAT) ? d_stat : (roff == OFF_REQ) ? d_req :
                                 (roff == OFF_MASK) ? d_mask : '0;
            default: reg_rdata = '0;
        endcase
    end

    // cross-bank resolution
    always_comb begin
        valid_d = 1'b1;
        vec_d   = '0;
        if (h_hit)      vec_d = HIGH_BASE + VEC_W'(h_idx);
        else if (d_hit) vec_d = DMA_BASE  + VEC_W'(d_idx);
        else if (l_hit) vec_d = LOW_BASE  + VEC_W'(l_idx);
        else            valid_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= valid_d;
            irq_vector <= vec_d;
        end
    end

    // R7
    pick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_hit |-> h_req[h_idx]);
    // R8
    pick_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_hit |-> (d_req[d_idx] && d_idx < 3'd6));
    // R9
    pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_hit |-> l_req[l_idx]);
    // R6
    high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req != '0) |=> (irq_valid && irq_vector[4:3] == 2'b01));
    // R6
    dma_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req == '0 && d_req != '0) |=> (irq_valid && irq_vector[4:3] == 2'b10));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vector == '0));
endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_low = '0, src_high = '0;
    logic [5:0] src_dma = '0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_valid;
    logic [4:0] irq_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_low(src_low), .src_high(src_high),
        .src_dma(src_dma), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_irq(input bit v, input int vec, input string req);
        check(irq_valid == v && irq_vector == 5'(vec), req,
              {irq_valid, irq_vector}, {v, 5'(vec)});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        expect_irq(1'b0, 0, "R3");
        rd(6'h18, d); check(d == 8'h00, "R3", d, 0);
        rd(6'h28, d); check(d == 8'h00, "R3", d, 0);
        rd(6'h38, d); check(d == 8'h00, "R3", d, 0);
    endtask

    task automatic t_map();
        logic [7:0] d;
        src_high = 8'hA5;
        wr(6'h28, 8'h0F);
        rd(6'h20, d); check(d == 8'hA5, "R1", d, 8'hA5);
        rd(6'h24, d); check(d == 8'h05, "R2", d, 8'h05);
        rd(6'h28, d); check(d == 8'h0F, "R1", d, 8'h0F);
        rd(6'h00, d); check(d == 8'h00, "R1", d, 0);
        rd(6'h2C, d); check(d == 8'h00, "R1", d, 0);
        wr(6'h28, 8'h00);
        settle();
        expect_irq(1'b0, 0, "R2");
        src_high = '0;
    endtask

    task automatic t_high_order();
        int ord[8] = '{2, 3, 5, 7, 6, 0, 1, 4};
        wr(6'h28, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] s = '0;
            for (int j = k; j < 8; j++) s[ord[j]] = 1'b1;
            src_high = s;
            settle();
            expect_irq(1'b1, 8 + ord[k], "R7");
        end
        src_high = '0;
        settle();
        expect_irq(1'b0, 0, "R7");
    endtask

    task automatic t_dma_order();
        int ord[6] = '{0, 1, 2, 3, 5, 4};
        wr(6'h38, 8'hFF);
        for (int k = 0; k < 6; k++) begin
            logic [5:0] s = '0;
            for (int j = k; j < 6; j++) s[ord[j]] = 1'b1;
            src_dma = s;
            settle();
            expect_irq(1'b1, 16 + ord[k], "R8");
        end
        src_dma = '0;
        settle();
    endtask

    task automatic t_low_order();
        int ord[8] = '{7, 5, 3, 6, 2, 0, 1, 4};
        logic [7:0] d;
        wr(6'h18, 8'hFF);
        @(negedge clk); src_low = 8'hFF;
        @(negedge clk); src_low = 8'h00;
        settle();
        rd(6'h10, d); check(d == 8'hFF, "R4", d, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            expect_irq(1'b1, ord[k], "R9");
            wr(6'h14, 8'(1 << ord[k]));
            settle();
        end
        expect_irq(1'b0, 0, "R4");
        rd(6'h10, d); check(d == 8'h00, "R4", d, 0);
    endtask

    task automatic t_noclr();
        logic [7:0] d;
        src_high = 8'h3C; src_dma = 6'h2A;
        wr(6'h24, 8'hFF);
        wr(6'h34, 8'hFF);
        rd(6'h20, d); check(d == 8'h3C, "R5", d, 8'h3C);
        rd(6'h30, d); check(d == 8'h2A, "R5", d, 8'h2A);
        src_high = '0; src_dma = '0;
        settle();
    endtask

    task automatic t_cross();
        @(negedge clk); src_low = 8'h01;
        @(negedge clk); src_low = 8'h00;
        src_dma = 6'h10; src_high = 8'h10;
        settle();
        expect_irq(1'b1, 12, "R6");
        src_high = '0; settle();
        expect_irq(1'b1, 20, "R6");
        src_dma = '0; settle();
        expect_irq(1'b1, 0, "R10");
        wr(6'h14, 8'h01); settle();
        expect_irq(1'b0, 0, "R10");
    endtask

    task automatic t_latency();
        @(negedge clk); src_high = 8'h01;
        #1 expect_irq(1'b0, 0, "R11");
        @(posedge clk); #1 expect_irq(1'b1, 8, "R11");
        @(negedge clk); src_high = '0;
        @(posedge clk); #1 expect_irq(1'b0, 0, "R11");
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        src_low = 8'h08; reg_addr = 6'h14; reg_wdata = 8'h08; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_low = 8'h00;
        rd(6'h10, d); check(d == 8'h08, "R12", d, 8'h08);
        wr(6'h14, 8'h08);
        rd(6'h10, d); check(d == 8'h00, "R12", d, 0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_map();
        t_high_order();
        t_dma_order();
        t_low_order();
        t_noclr();
        t_cross();
        t_latency();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule